// File: doc/BRIEF.md
# Vector-Priority Interrupt Acceptance Unit

This block collects interrupt requests, each named by an 8-bit vector, and offers the most urgent one to the processor. A vector's priority class is its upper four bits. Each accepted request sets a bit in a 256-bit pending register. Each class has room for one held request and one request in service. A request that finds its class's holding slot already taken is dropped, and a one-cycle lost flag is raised.

A pending request is offered on the dispatch port only when its class is strictly above two things: the programmed task-priority class and the class of the highest vector now in service. The processor accepts the offer with an acknowledge. That moves the vector from pending to in-service on the same clock edge. An end-of-interrupt strobe retires the highest in-service vector.

The in-service state can be read out through a bank-select port, 32 bits at a time. The highest in-service vector is also driven on its own output.

Top module: `intr_accept_unit`

## Requirements
- R1: A request whose vector is below 32 is discarded. It sets no pending bit, raises no lost flag and leaves every output unchanged.
- R2: The class of a vector is bits [7:4]. A pending vector is offered only when its class is strictly greater than the task-priority class, which is written through `tpr_we_i`/`tpr_class_i`.
- R3: While the task-priority class is 15, `disp_valid_o` stays low.
- R4: A pending vector is offered only when its class is strictly greater than the class of the highest in-service vector. An equal class waits.
- R5: When a pending vector is offered, it is the highest-numbered pending vector.
- R6: When `disp_ack_i` is high while `disp_valid_o` is high, the offered vector leaves the pending set and enters the in-service set at that clock edge.
- R7: Each class holds at most one pending vector. A legal request into a class whose pending slot is occupied is dropped. `lost_o` is then high for exactly the one cycle after that edge. If the same class has a request in service but no pending vector, the new request is still accepted.
- R8: On `eoi_i`, only the highest in-service vector is cleared.
- R9: Bit j of `bank_data_o` is the in-service state of vector 32*`bank_sel_i`+j. The output follows `bank_sel_i` without a clock.
- R10: `cur_vector_o` is the highest in-service vector, and `cur_valid_o` is high when any vector is in service. When none is in service, `cur_valid_o` is 0 and `cur_vector_o` is 0.
- R11: Reset (`rst_ni` low, asynchronous) clears every pending and in-service bit, clears `lost_o` and sets the task-priority class to 0.
- R12: `disp_ack_i` while `disp_valid_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_vector_i | input | 8 | Requested vector |
| tpr_we_i | input | 1 | Task-priority class write enable |
| tpr_class_i | input | 4 | New task-priority class |
| disp_valid_o | output | 1 | A vector is offered to the processor |
| disp_vector_o | output | 8 | Offered vector |
| disp_ack_i | input | 1 | Processor takes the offered vector |
| eoi_i | input | 1 | End of interrupt for the highest in-service vector |
| cur_valid_o | output | 1 | Some vector is in service |
| cur_vector_o | output | 8 | Highest in-service vector |
| lost_o | output | 1 | Request dropped in the previous cycle |
| bank_sel_i | input | 3 | In-service bank select |
| bank_data_o | output | 32 | In-service bits of the selected bank |

## Verification
The bench targets equal-class cases. A pending vector whose class matches the in-service class must wait. A design comparing with >= would dispatch it early and nest an interrupt into its own class. It checks that a dropped request does not land: after the class is retired, the surviving vector 0x41 must be offered. A design that merged 0x4F into the pending set would offer 0x4F instead. It also sends reserved vectors, an acknowledge with nothing offered, and a reset in the middle of a run. These catch a design that latches low vectors, that moves state on a stray acknowledge, or that keeps the task-priority class across reset.

// File: rtl/intr_accept_pkg.sv
package intr_accept_pkg;
  localparam int unsigned DEF_VEC_W    = 8;
  localparam int unsigned DEF_CLASS_W  = 4;
  localparam int unsigned DEF_BANK_W   = 32;
  localparam int unsigned DEF_RSVD_VEC = 32;
endpackage

// File: rtl/intr_prio_enc.sv
module intr_prio_enc #(
  parameter int unsigned W     = 256,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // highest set bit wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intr_pend_reg.sv
module intr_pend_reg #(
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned CLASS_W  = 4,
  parameter int unsigned RSVD_VEC = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [VEC_W-1:0]        req_vector_i,
  input  logic                    clr_en_i,
  input  logic [VEC_W-1:0]        clr_vector_i,
  output logic [(1<<VEC_W)-1:0]   pend_o,
  output logic                    lost_o
);
  localparam int unsigned NUM_VEC   = 1 << VEC_W;
  localparam int unsigned NUM_CLASS = 1 << CLASS_W;
  localparam int unsigned CLASS_SZ  = NUM_VEC / NUM_CLASS;

  logic [NUM_VEC-1:0]   pend_q, pend_d, pend_kept, clr_mask, set_mask;
  logic [NUM_CLASS-1:0] class_busy;
  logic [CLASS_W-1:0]   req_class;
  logic                 req_legal, accept, lost_q;

  assign clr_mask  = clr_en_i ? (NUM_VEC'(1) << clr_vector_i) : '0;
  assign pend_kept = pend_q & ~clr_mask;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
    assign class_busy[c] = |pend_kept[c*CLASS_SZ +: CLASS_SZ];
  end

  assign req_class = req_vector_i[VEC_W-1 -: CLASS_W];
  assign req_legal = req_valid_i && (32'(req_vector_i) >= RSVD_VEC);
  assign accept    = req_legal && !class_busy[req_class];
  assign set_mask  = accept ? (NUM_VEC'(1) << req_vector_i) : '0;
  assign pend_d    = pend_kept | set_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      lost_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      lost_q <= req_legal && class_busy[req_class];
    end
  end

  assign pend_o = pend_q;
  assign lost_o = lost_q;
endmodule

// File: rtl/intr_svc_reg.sv
module intr_svc_reg #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned BANK_W = 32,
  parameter int unsigned BSEL_W = $clog2((1 << VEC_W) / BANK_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_en_i,
  input  logic [VEC_W-1:0]      set_vector_i,
  input  logic                  eoi_i,
  input  logic [BSEL_W-1:0]     bank_sel_i,
  output logic [BANK_W-1:0]     bank_data_o,
  output logic [(1<<VEC_W)-1:0] svc_o,
  output logic                  top_valid_o,
  output logic [VEC_W-1:0]      top_vector_o
);
  localparam int unsigned NUM_VEC  = 1 << VEC_W;
  localparam int unsigned NUM_BANK = NUM_VEC / BANK_W;

  logic [NUM_VEC-1:0] svc_q, set_mask, eoi_mask;
  logic [BANK_W-1:0]  banks [NUM_BANK];
  logic               top_any;
  logic [VEC_W-1:0]   top_idx;

  intr_prio_enc #(.W(NUM_VEC), .IDX_W(VEC_W)) u_top_enc (
    .vec_i (svc_q),
    .any_o (top_any),
    .idx_o (top_idx)
  );

  assign set_mask = set_en_i ? (NUM_VEC'(1) << set_vector_i) : '0;
  assign eoi_mask = (eoi_i && top_any) ? (NUM_VEC'(1) << top_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) svc_q <= '0;
    else         svc_q <= (svc_q & ~eoi_mask) | set_mask;
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    assign banks[b] = svc_q[b*BANK_W +: BANK_W];
  end

  assign bank_data_o  = banks[bank_sel_i];
  assign svc_o        = svc_q;
  assign top_valid_o  = top_any;
  assign top_vector_o = top_any ? top_idx : '0;
endmodule

// File: rtl/intr_accept_unit.sv
module intr_accept_unit
  import intr_accept_pkg::*;
#(
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned CLASS_W  = DEF_CLASS_W,
  parameter int unsigned BANK_W   = DEF_BANK_W,
  parameter int unsigned RSVD_VEC = DEF_RSVD_VEC,
  parameter int unsigned BSEL_W   = $clog2((1 << VEC_W) / BANK_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [VEC_W-1:0]   req_vector_i,
  input  logic               tpr_we_i,
  input  logic [CLASS_W-1:0] tpr_class_i,
  output logic               disp_valid_o,
  output logic [VEC_W-1:0]   disp_vector_o,
  input  logic               disp_ack_i,
  input  logic               eoi_i,
  output logic               cur_valid_o,
  output logic [VEC_W-1:0]   cur_vector_o,
  output logic               lost_o,
  input  logic [BSEL_W-1:0]  bank_sel_i,
  output logic [BANK_W-1:0]  bank_data_o
);
  localparam int unsigned NUM_VEC = 1 << VEC_W;

  logic [NUM_VEC-1:0] pend_vec, svc_vec;
  logic [CLASS_W-1:0] tpr_q, pend_class, svc_class;
  logic [VEC_W-1:0]   pend_top;
  logic               pend_any, take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tpr_q <= '0;
    else if (tpr_we_i) tpr_q <= tpr_class_i;
  end

  intr_pend_reg #(.VEC_W(VEC_W), .CLASS_W(CLASS_W), .RSVD_VEC(RSVD_VEC)) u_pend (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_vector_i (req_vector_i),
    .clr_en_i     (take),
    .clr_vector_i (pend_top),
    .pend_o       (pend_vec),
    .lost_o       (lost_o)
  );

  intr_prio_enc #(.W(NUM_VEC), .IDX_W(VEC_W)) u_pend_enc (
    .vec_i (pend_vec),
    .any_o (pend_any),
    .idx_o (pend_top)
  );

  intr_svc_reg #(.VEC_W(VEC_W), .BANK_W(BANK_W), .BSEL_W(BSEL_W)) u_svc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_en_i     (take),
    .set_vector_i (pend_top),
    .eoi_i        (eoi_i),
    .bank_sel_i   (bank_sel_i),
    .bank_data_o  (bank_data_o),
    .svc_o        (svc_vec),
    .top_valid_o  (cur_valid_o),
    .top_vector_o (cur_vector_o)
  );

  // highest pending carries the highest class, so only it needs gating
  assign pend_class    = pend_top[VEC_W-1 -: CLASS_W];
  assign svc_class     = cur_vector_o[VEC_W-1 -: CLASS_W];
  assign disp_valid_o  = pend_any && (pend_class > tpr_q) &&
                         (!cur_valid_o || (pend_class > svc_class));
  assign disp_vector_o = pend_top;
  assign take          = disp_valid_o && disp_ack_i;
endmodule

// File: rtl/intr_accept_unit_chk.sv
module intr_accept_unit_chk #(
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned CLASS_W  = 4,
  parameter int unsigned RSVD_VEC = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  disp_valid_o,
  input logic [VEC_W-1:0]      disp_vector_o,
  input logic                  disp_ack_i,
  input logic                  eoi_i,
  input logic                  cur_valid_o,
  input logic [VEC_W-1:0]      cur_vector_o,
  input logic                  lost_o,
  input logic [(1<<VEC_W)-1:0] pend_i,
  input logic [(1<<VEC_W)-1:0] svc_i,
  input logic [CLASS_W-1:0]    tpr_i
);
  localparam int unsigned NUM_CLASS = 1 << CLASS_W;
  localparam int unsigned CLASS_SZ  = (1 << VEC_W) / NUM_CLASS;

  // R1
  no_rsvd_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i[RSVD_VEC-1:0] == '0) && (svc_i[RSVD_VEC-1:0] == '0));

  // R2
  above_tpr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (disp_vector_o[VEC_W-1 -: CLASS_W] > tpr_i));

  // R3
  tpr_full_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tpr_i == {CLASS_W{1'b1}}) |-> !disp_valid_o);

  // R4
  above_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && cur_valid_o) |->
      (disp_vector_o[VEC_W-1 -: CLASS_W] > cur_vector_o[VEC_W-1 -: CLASS_W]));

  // R6
  ack_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && disp_ack_i) |=> svc_i[$past(disp_vector_o)]);

  // R7
  lost_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> $past(req_valid_i));

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    // R7
    one_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(pend_i[c*CLASS_SZ +: CLASS_SZ]) <= 1);
  end

  // R8
  eoi_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && cur_valid_o) |=> !svc_i[$past(cur_vector_o)]);

  // R10
  cur_in_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_valid_o |-> svc_i[cur_vector_o]);

  // R10
  cur_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_valid_o |-> (svc_i == '0));
endmodule

bind intr_accept_unit intr_accept_unit_chk #(
  .VEC_W(VEC_W), .CLASS_W(CLASS_W), .RSVD_VEC(RSVD_VEC)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .disp_valid_o  (disp_valid_o),
  .disp_vector_o (disp_vector_o),
  .disp_ack_i    (disp_ack_i),
  .eoi_i         (eoi_i),
  .cur_valid_o   (cur_valid_o),
  .cur_vector_o  (cur_vector_o),
  .lost_o        (lost_o),
  .pend_i        (pend_vec),
  .svc_i         (svc_vec),
  .tpr_i         (tpr_q)
);

// File: tb/intr_accept_unit_tb_top.sv
module intr_accept_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [7:0]  req_vector_i = '0;
  logic        tpr_we_i = 1'b0;
  logic [3:0]  tpr_class_i = '0;
  logic        disp_ack_i = 1'b0;
  logic        eoi_i = 1'b0;
  logic [2:0]  bank_sel_i = '0;
  logic        disp_valid_o, cur_valid_o, lost_o;
  logic [7:0]  disp_vector_o, cur_vector_o;
  logic [31:0] bank_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  intr_accept_unit dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_vector_i, .tpr_we_i, .tpr_class_i,
    .disp_valid_o, .disp_vector_o, .disp_ack_i, .eoi_i,
    .cur_valid_o, .cur_vector_o, .lost_o, .bank_sel_i, .bank_data_o
  );

  typedef struct packed {
    logic       req;
    logic [7:0] vec;
    logic       tw;
    logic [3:0] tc;
    logic       ack;
    logic       eoi;
    logic       dv;
    logic [7:0] dvec;
    logic       lost;
    logic       cv;
    logic [7:0] cur;
    logic [3:0] rq;
  } row_t;

  // req vec tw tc ack eoi | dv dvec lost cv cur | req tag
  localparam row_t ROWS [16] = '{
    '{1'b1, 8'h10, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd1 },  // R1 reserved
    '{1'b1, 8'h45, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 8'h45, 1'b0, 1'b0, 8'h00, 4'd2 },  // R2
    '{1'b1, 8'h47, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 8'h45, 1'b1, 1'b0, 8'h00, 4'd7 },  // R7 slot taken
    '{1'b1, 8'h93, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 8'h93, 1'b0, 1'b0, 8'h00, 4'd5 },  // R5
    '{1'b0, 8'h00, 1'b1, 4'h9, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd2 },  // R2 tie with tpr
    '{1'b0, 8'h00, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd3 },  // R3
    '{1'b0, 8'h00, 1'b1, 4'h3, 1'b0, 1'b0, 1'b1, 8'h93, 1'b0, 1'b0, 8'h00, 4'd2 },  // R2
    '{1'b0, 8'h00, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h93, 4'd6 },  // R6
    '{1'b1, 8'h9A, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h93, 4'd4 },  // R4 tie
    '{1'b1, 8'hB1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 8'hB1, 1'b0, 1'b1, 8'h93, 4'd4 },  // R4 nest
    '{1'b0, 8'h00, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'hB1, 4'd6 },  // R6
    '{1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h93, 4'd8 },  // R8
    '{1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 8'h9A, 1'b0, 1'b0, 8'h00, 4'd8 },  // R8 R10
    '{1'b0, 8'h00, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h9A, 4'd6 },  // R6
    '{1'b0, 8'h00, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h9A, 4'd12},  // R12 stray ack
    '{1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 8'h45, 1'b0, 1'b0, 8'h00, 4'd10}   // R10
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic req, input logic [7:0] vec, input logic tw,
                      input logic [3:0] tc, input logic ack, input logic eoi);
    @(negedge clk_i);
    req_valid_i = req; req_vector_i = vec; tpr_we_i = tw; tpr_class_i = tc;
    disp_ack_i = ack; eoi_i = eoi;
    @(posedge clk_i);
    #1;
    req_valid_i = 1'b0; tpr_we_i = 1'b0; disp_ack_i = 1'b0; eoi_i = 1'b0;
  endtask

  task automatic chk_out(input string rq, input logic dv, input logic [7:0] dvec,
                         input logic lost, input logic cv, input logic [7:0] cur);
    chk(disp_valid_o == dv, rq, "disp_valid", disp_valid_o, dv);
    if (dv) chk(disp_vector_o == dvec, rq, "disp_vector", disp_vector_o, dvec);
    chk(lost_o == lost, rq, "lost", lost_o, lost);
    chk(cur_valid_o == cv, rq, "cur_valid", cur_valid_o, cv);
    chk(cur_vector_o == cur, rq, "cur_vector", cur_vector_o, cur);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R11 reset state
    chk_out("R11", 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < 16; i++) begin
      step(ROWS[i].req, ROWS[i].vec, ROWS[i].tw, ROWS[i].tc, ROWS[i].ack, ROWS[i].eoi);
      chk_out($sformatf("R%0d row%0d", ROWS[i].rq, i), ROWS[i].dv, ROWS[i].dvec,
              ROWS[i].lost, ROWS[i].cv, ROWS[i].cur);
    end

    // R9 / R6: take 0x45, read it in bank 2 bit 5
    step(1'b0, 8'h00, 1'b0, 4'h0, 1'b1, 1'b0);
    chk_out("R6", 1'b0, 8'h00, 1'b0, 1'b1, 8'h45);
    bank_sel_i = 3'd2; #1;
    chk(bank_data_o == 32'h0000_0020, "R9", "bank2", bank_data_o, 32'h20);
    bank_sel_i = 3'd0; #1;
    chk(bank_data_o == 32'h0, "R9", "bank0", bank_data_o, 0);

    // R7: class 4 in service, holding slot free -> accepted
    step(1'b1, 8'h41, 1'b0, 4'h0, 1'b0, 1'b0);
    chk_out("R7 second", 1'b0, 8'h00, 1'b0, 1'b1, 8'h45);
    // R7: third entry in class 4 is lost
    step(1'b1, 8'h4F, 1'b0, 4'h0, 1'b0, 1'b0);
    chk_out("R7 third", 1'b0, 8'h00, 1'b1, 1'b1, 8'h45);
    step(1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b0);
    chk(lost_o == 1'b0, "R7", "lost pulse end", lost_o, 0);
    // R1: reserved vector has no effect
    step(1'b1, 8'h1F, 1'b0, 4'h0, 1'b0, 1'b0);
    chk_out("R1", 1'b0, 8'h00, 1'b0, 1'b1, 8'h45);
    chk(bank_data_o == 32'h0, "R1", "bank0 after reserved", bank_data_o, 0);
    // R7: dropped 0x4F never landed, 0x41 is offered
    step(1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1);
    chk_out("R7 survivor", 1'b1, 8'h41, 1'b0, 1'b0, 8'h00);

    // R11: asynchronous reset mid-run, then tpr back to 0
    step(1'b0, 8'h00, 1'b1, 4'h8, 1'b1, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk_out("R11 mid", 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    bank_sel_i = 3'd2; #1;
    chk(bank_data_o == 32'h0, "R11", "bank2 cleared", bank_data_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b1, 8'h25, 1'b0, 4'h0, 1'b0, 1'b0);
    chk_out("R11 tpr0", 1'b1, 8'h25, 1'b0, 1'b0, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1..all actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule